// File: doc/BRIEF.md
# Mixed-Radix DFT Loop and Address Sequencer

This block is the control unit for a two-stage row/column DFT whose transform size is chosen at run time. A size index selects an entry in an internal parameter table. The entry gives the length N and its split into two factors N1 and N2. A start pulse loads that entry, and the block then walks four phases back to back: column DFTs, twiddle multiplication, row DFTs and output readout. In each cycle it presents one read address, one write address with its enable, and during the twiddle phase the twiddle exponent for the element being addressed.

Addresses assume a single working memory of N words that holds the input x[n] in natural order. The column phase updates this memory in place. The row phase scatters its results so that the final readout, at addresses 0 to N-1 in order, returns output bins in natural frequency order with no reorder buffer. The arithmetic datapath and the twiddle value store sit outside this block.

Top module: `dft_seq`

## Requirements
- R1: After reset and while idle, busy_o, done_o, err_o, addr_vld_o and wr_en_o are 0, and phase_o, rd_addr_o, wr_addr_o and twid_exp_o are 0.
- R2: Index values 0 to 34 select, in ascending order, the 35 lengths 12·k where k ≤ 108 has no prime factor other than 2, 3 or 5 (12 up to 1296). Index values 35 to 41 select 2^4 up to 2^10. For each length, N1 is the largest divisor of N not above 36, and N2 = N/N1.
- R3: A start_i pulse with a valid index while idle raises busy_o and addr_vld_o in the next cycle. The block then runs the phases column (code 0), twiddle (1), row (2) and output (3), each for exactly N cycles, with phase_o showing the code.
- R4: In the column phase, at cycle c of that phase, with n2 = c/N1 and n1 = c mod N1, rd_addr_o = wr_addr_o = N2·n1 + n2, wr_en_o = 1 and twid_exp_o = 0.
- R5: In the twiddle phase, at cycle c, rd_addr_o = wr_addr_o = c, wr_en_o = 1 and twid_exp_o = (c/N2)·(c mod N2), which is always below N. In every other phase and while idle, twid_exp_o is 0.
- R6: In the row phase, at cycle c, rd_addr_o = c, wr_en_o = 1 and wr_addr_o = (c/N2) + N1·(c mod N2).
- R7: In the output phase, at cycle c, rd_addr_o = c (natural bin order), wr_en_o = 0 and wr_addr_o = 0.
- R8: done_o is 1 for exactly the one cycle after the last output-phase address. In that cycle busy_o and addr_vld_o are already 0.
- R9: While busy, start_i is ignored whatever size_idx_i holds: the address sequence goes on unchanged and err_o stays 0.
- R10: A start_i pulse while idle with an index of 42 or above sets err_o for exactly one cycle, and busy_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a transform |
| size_idx_i | input | 6 | Transform size selector |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | One-cycle pulse for a rejected index |
| addr_vld_o | output | 1 | Address outputs are meaningful |
| phase_o | output | 2 | Current phase code |
| rd_addr_o | output | 11 | Working-memory read address |
| wr_addr_o | output | 11 | Working-memory write address |
| wr_en_o | output | 1 | Write enable for wr_addr_o |
| twid_exp_o | output | 11 | Twiddle exponent for the twiddle multiplier |

## Verification
The bench builds the block with its default table bounds: base unit 12, multiplier limit 108, factor cap 36 and power-of-two exponents 4 to 10. This means 42 entries and an 11-bit address. All 42 entries are run to completion, so the smallest case, where N2 = 1 (12 and 16 points), and the largest, where N1 = N2 = 36 (1296 points), are both reached. So are entries where N2 is larger than N1, such as 1200 = 30 × 40. Restart attempts during a run use an index that is valid and one that is out of range. The rejection path is driven with the first index past the table and with the highest index.

// File: rtl/dft_seq_pkg.sv
package dft_seq_pkg;

  localparam int unsigned LTE_UNIT  = 12;
  localparam int unsigned LTE_K_MAX = 108;
  localparam int unsigned NUM_LTE   = 35;
  localparam int unsigned P2_LO     = 4;
  localparam int unsigned P2_HI     = 10;
  localparam int unsigned MAX_FAC   = 36;
  localparam int unsigned NUM_ENT   = NUM_LTE + P2_HI - P2_LO + 1;
  localparam int unsigned N_MAX     = LTE_UNIT * LTE_K_MAX;
  localparam int unsigned AW        = $clog2(N_MAX);
  localparam int unsigned IW        = $clog2(NUM_ENT);

  typedef enum logic [1:0] {
    PH_COL  = 2'd0,
    PH_TWID = 2'd1,
    PH_ROW  = 2'd2,
    PH_OUT  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [AW-1:0] n;
    logic [AW-1:0] n1;
    logic [AW-1:0] n2;
  } dims_t;

  function automatic bit is_smooth(int unsigned v);
    int unsigned m;
    m = v;
    for (int r = 0; r < int'(AW); r++) begin
      if (m % 2 == 0) m = m / 2;
      else if (m % 3 == 0) m = m / 3;
      else if (m % 5 == 0) m = m / 5;
    end
    return m == 1;
  endfunction

  function automatic int unsigned entry_n(int unsigned i);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 0;
    if (i < NUM_LTE) begin
      for (int unsigned k = 1; k <= LTE_K_MAX; k++) begin
        if (is_smooth(k)) begin
          if (cnt == i) res = LTE_UNIT * k;
          cnt++;
        end
      end
    end else begin
      res = 1 << (P2_LO + i - NUM_LTE);
    end
    return res;
  endfunction

  function automatic int unsigned entry_n1(int unsigned n);
    int unsigned best;
    best = 1;
    for (int unsigned d = 1; d <= MAX_FAC; d++)
      if (n % d == 0) best = d;
    return best;
  endfunction

endpackage

// File: rtl/dft_size_rom.sv
module dft_size_rom
  import dft_seq_pkg::*;
(
  input  logic [IW-1:0] idx_i,
  output dims_t         dims_o,
  output logic          ok_o
);

  dims_t tbl [NUM_ENT];

  for (genvar g = 0; g < int'(NUM_ENT); g++) begin : g_ent
    localparam int unsigned EN  = entry_n(g);
    localparam int unsigned EN1 = entry_n1(EN);
    assign tbl[g] = '{n: AW'(EN), n1: AW'(EN1), n2: AW'(EN / EN1)};
  end

  always_comb begin
    dims_o = '0;
    ok_o   = 1'b0;
    for (int e = 0; e < int'(NUM_ENT); e++) begin
      if (idx_i == IW'(e)) begin
        dims_o = tbl[e];
        ok_o   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dft_loop_ctr.sv
module dft_loop_ctr
  import dft_seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ok_i,
  input  dims_t         dims_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output phase_e        phase_o,
  output logic [AW-1:0] lin_o,
  output logic [AW-1:0] inner_o,
  output logic [AW-1:0] outer_o,
  output dims_t         dims_o
);

  logic          busy_q, done_q, err_q;
  phase_e        phase_q;
  logic [AW-1:0] lin_q, inner_q, outer_q;
  dims_t         dims_q;
  logic [AW-1:0] ilim;

  // column loops run n1 fastest; all later phases run the second factor fastest
  assign ilim = (phase_q == PH_COL) ? dims_q.n1 : dims_q.n2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      phase_q <= PH_COL;
      lin_q   <= '0;
      inner_q <= '0;
      outer_q <= '0;
      dims_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          if (ok_i) begin
            busy_q  <= 1'b1;
            dims_q  <= dims_i;
            phase_q <= PH_COL;
            lin_q   <= '0;
            inner_q <= '0;
            outer_q <= '0;
          end else begin
            err_q <= 1'b1;
          end
        end
      end else if (lin_q == dims_q.n - AW'(1)) begin
        lin_q   <= '0;
        inner_q <= '0;
        outer_q <= '0;
        if (phase_q == PH_OUT) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          phase_q <= PH_COL;
        end else begin
          phase_q <= phase_e'(phase_q + 2'd1);
        end
      end else begin
        lin_q <= lin_q + AW'(1);
        if (inner_q == ilim - AW'(1)) begin
          inner_q <= '0;
          outer_q <= outer_q + AW'(1);
        end else begin
          inner_q <= inner_q + AW'(1);
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign phase_o = phase_q;
  assign lin_o   = lin_q;
  assign inner_o = inner_q;
  assign outer_o = outer_q;
  assign dims_o  = dims_q;

endmodule

// File: rtl/dft_addr_gen.sv
module dft_addr_gen
  import dft_seq_pkg::*;
(
  input  logic          busy_i,
  input  phase_e        phase_i,
  input  logic [AW-1:0] lin_i,
  input  logic [AW-1:0] inner_i,
  input  logic [AW-1:0] outer_i,
  input  dims_t         dims_i,
  output logic          vld_o,
  output logic [AW-1:0] rd_o,
  output logic [AW-1:0] wr_o,
  output logic          we_o,
  output logic [AW-1:0] exp_o
);

  always_comb begin
    vld_o = 1'b0;
    rd_o  = '0;
    wr_o  = '0;
    we_o  = 1'b0;
    exp_o = '0;
    if (busy_i) begin
      vld_o = 1'b1;
      unique case (phase_i)
        PH_COL: begin
          // stride-N2 gather, in-place update
          rd_o = dims_i.n2 * inner_i + outer_i;
          wr_o = rd_o;
          we_o = 1'b1;
        end
        PH_TWID: begin
          rd_o  = lin_i;
          wr_o  = lin_i;
          we_o  = 1'b1;
          exp_o = outer_i * inner_i;
        end
        PH_ROW: begin
          // scatter to k1 + N1*k2 so readout is natural order
          rd_o = lin_i;
          wr_o = outer_i + dims_i.n1 * inner_i;
          we_o = 1'b1;
        end
        default: begin
          rd_o = lin_i;
        end
      endcase
    end
  end

endmodule

// File: rtl/dft_seq.sv
module dft_seq
  import dft_seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] size_idx_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          addr_vld_o,
  output logic [1:0]    phase_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] twid_exp_o
);

  dims_t         rom_dims, run_dims;
  logic          rom_ok;
  phase_e        phase;
  logic [AW-1:0] lin, inner, outer;

  dft_size_rom u_rom (
    .idx_i  (size_idx_i),
    .dims_o (rom_dims),
    .ok_o   (rom_ok)
  );

  dft_loop_ctr u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ok_i    (rom_ok),
    .dims_i  (rom_dims),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .phase_o (phase),
    .lin_o   (lin),
    .inner_o (inner),
    .outer_o (outer),
    .dims_o  (run_dims)
  );

  dft_addr_gen u_agen (
    .busy_i  (busy_o),
    .phase_i (phase),
    .lin_i   (lin),
    .inner_i (inner),
    .outer_i (outer),
    .dims_i  (run_dims),
    .vld_o   (addr_vld_o),
    .rd_o    (rd_addr_o),
    .wr_o    (wr_addr_o),
    .we_o    (wr_en_o),
    .exp_o   (twid_exp_o)
  );

  assign phase_o = phase;

endmodule

// File: rtl/dft_seq_chk.sv
module dft_seq_chk
  import dft_seq_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [IW-1:0] size_idx_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          addr_vld_o,
  input logic [1:0]    phase_o,
  input logic [AW-1:0] rd_addr_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          wr_en_o,
  input logic [AW-1:0] twid_exp_o
);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o && !addr_vld_o));

  // R10
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !$past(busy_o)));

  // R10
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  // R3
  phase_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      (phase_o == $past(phase_o) || phase_o == $past(phase_o) + 2'd1));

  // R3
  start_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (phase_o == 2'd0 && rd_addr_o == '0));

  // R5
  twid_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (twid_exp_o != '0) |-> (busy_o && phase_o == 2'd1));

  // R7
  out_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && phase_o == 2'd3) |-> !wr_en_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!addr_vld_o && !wr_en_o && rd_addr_o == '0));

  // R4
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> (rd_addr_o < AW'(N_MAX) && wr_addr_o < AW'(N_MAX)));

endmodule

bind dft_seq dft_seq_chk u_chk (.*);

// File: tb/dft_seq_tb.sv
`timescale 1ns/1ps
module dft_seq_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  size_idx_i = '0;
  logic        busy_o, done_o, err_o, addr_vld_o, wr_en_o;
  logic [1:0]  phase_o;
  logic [10:0] rd_addr_o, wr_addr_o, twid_exp_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  int sizes[$];

  always #4 clk_i = ~clk_i;

  dft_seq u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .size_idx_i (size_idx_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .addr_vld_o (addr_vld_o),
    .phase_o    (phase_o),
    .rd_addr_o  (rd_addr_o),
    .wr_addr_o  (wr_addr_o),
    .wr_en_o    (wr_en_o),
    .twid_exp_o (twid_exp_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, "busy", int'(busy_o), 0);
    chk(req, "addr_vld", int'(addr_vld_o), 0);
    chk(req, "wr_en", int'(wr_en_o), 0);
    chk(req, "phase", int'(phase_o), 0);
    chk(req, "rd_addr", int'(rd_addr_o), 0);
    chk(req, "wr_addr", int'(wr_addr_o), 0);
    chk(req, "twid_exp", int'(twid_exp_o), 0);
  endtask

  // R2: ascending 12*k with 5-smooth k up to 108, then 2^4..2^10
  function automatic void build_sizes();
    for (int m = 12; m <= 1296; m += 12) begin
      int r = m / 12;
      while (r % 2 == 0) r /= 2;
      while (r % 3 == 0) r /= 3;
      while (r % 5 == 0) r /= 5;
      if (r == 1) sizes.push_back(m);
    end
    for (int p = 4; p <= 10; p++) sizes.push_back(1 << p);
  endfunction

  function automatic int pick_n1(int n);
    for (int d = 36; d >= 1; d--)
      if (n % d == 0) return d;
    return 1;
  endfunction

  task automatic run_size(int idx, int poke_idx);
    int n  = sizes[idx];
    int n1 = pick_n1(n);
    int n2 = n / n1;
    @(negedge clk_i);
    start_i = 1'b1;
    size_idx_i = 6'(idx);
    @(negedge clk_i);
    start_i = 1'b0;
    size_idx_i = 6'd63;
    for (int ph = 0; ph < 4; ph++) begin
      for (int c = 0; c < n; c++) begin
        int erd, ewr, ewe, eex;
        string rq;
        eex = 0;
        case (ph)
          0: begin rq = "R4 R2"; erd = n2 * (c % n1) + c / n1; ewr = erd; ewe = 1; end
          1: begin rq = "R5"; erd = c; ewr = c; ewe = 1; eex = (c / n2) * (c % n2); end
          2: begin rq = "R6 R2"; erd = c; ewr = c / n2 + n1 * (c % n2); ewe = 1; end
          default: begin rq = "R7"; erd = c; ewr = 0; ewe = 0; end
        endcase
        chk("R3", "busy", int'(busy_o), 1);
        chk("R3", "addr_vld", int'(addr_vld_o), 1);
        chk("R3", "phase", int'(phase_o), ph);
        chk("R8", "done", int'(done_o), 0);
        chk("R9", "err", int'(err_o), 0);
        chk(rq, "rd_addr", int'(rd_addr_o), erd);
        chk(rq, "wr_addr", int'(wr_addr_o), ewr);
        chk(rq, "wr_en", int'(wr_en_o), ewe);
        chk(rq, "twid_exp", int'(twid_exp_o), eex);
        if (poke_idx >= 0 && ((ph == 1 && c == 0) || (ph == 3 && c == n - 1))) begin
          start_i = 1'b1;
          size_idx_i = 6'(poke_idx);
        end
        @(negedge clk_i);
        start_i = 1'b0;
      end
    end
    chk("R8", "done", int'(done_o), 1);
    chk("R8", "busy", int'(busy_o), 0);
    chk("R8", "addr_vld", int'(addr_vld_o), 0);
    @(negedge clk_i);
    chk("R8", "done_after", int'(done_o), 0);
    chk("R9", "err_after", int'(err_o), 0);
    chk_idle("R1");
  endtask

  task automatic reject(int idx);
    @(negedge clk_i);
    start_i = 1'b1;
    size_idx_i = 6'(idx);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10", "err", int'(err_o), 1);
    chk("R10", "busy", int'(busy_o), 0);
    chk("R10", "addr_vld", int'(addr_vld_o), 0);
    @(negedge clk_i);
    chk("R10", "err_after", int'(err_o), 0);
    chk("R10", "busy_after", int'(busy_o), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    build_sizes();
    repeat (3) @(negedge clk_i);
    chk_idle("R1");
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "err", int'(err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1");
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "err", int'(err_o), 0);
    reject(42);
    reject(63);
    for (int i = 0; i < sizes.size(); i++) begin
      int pk;
      if (i == 0) pk = 63;
      else if (i == 21) pk = 34;
      else if (i == 40) pk = 0;
      else pk = -1;
      run_size(i, pk);
    end
    reject(42);
    summary();
  end

endmodule